// File: doc/BRIEF.md
# Compressed Program Counter Trace Packer

This block turns a stream of executed-opcode program counters into fixed 20-bit trace rows. The goal is to get more history out of a trace buffer of a given depth. Every opcode that the core reports counts, illegal ones included. While execution stays inside one 64-byte region, only the 6-bit offset of each PC within that region is recorded, and three offsets share a single row. When execution leaves the region, the block writes a row that carries the whole 18-bit PC. The 2-bit tag at the top of each row tells a decoder which kind of row it is reading.

The block sits between the core's retire strobe and a trace buffer's write port. Tracing runs while `trace_en` is high. A `flush` pulse, or dropping `trace_en`, drains any half-filled row so that nothing recorded is lost. After a drain, the next opcode restarts the stream with a full-PC row. The block writes at most one row per clock. When a region change has to emit both a half-filled offset row and a full-PC row, the full-PC row is held in a one-entry slot and written on the following cycle.

Top module: `pc_trace_packer`

## Requirements
- R1: A row is 20 bits: bits 19:18 are the tag and bits 17:0 the payload. A row is written (`row_valid` high for one cycle) in the cycle after the clock edge that accepted the stimulus producing it.
- R2: The first opcode accepted after reset, after `trace_en` rises, or after a drain produces a full-PC row: tag 00 and payload equal to the opcode's PC.
- R3: An opcode whose PC bits 17:6 match the current region is recorded as the offset PC[5:0]. The first offset goes in payload bits 5:0, the second in bits 11:6 and the third in bits 17:12. Nothing is written until the third offset arrives, and then a row with tag 11 is written.
- R4: An opcode outside the current region, arriving when no offsets are pending, produces a full-PC row at once and makes its region current.
- R5: An opcode outside the current region, arriving when offsets are pending, first writes the pending offsets as a partial row (tag 01 for one offset, tag 10 for two). The opcode's full-PC row follows on the next cycle.
- R6: If a further opcode arrives while a full-PC row is still waiting to be written, the waiting row is written in that cycle and the stream order is kept. An out-of-region opcode becomes the new waiting row. An in-region opcode starts a new offset row.
- R7: A `flush` pulse while tracing writes the waiting full-PC row if there is one, otherwise writes the pending offsets with their count tag, otherwise writes nothing. An opcode in the same cycle as the pulse is ignored. The region is forgotten.
- R8: While `trace_en` is low, opcodes are ignored and no rows are written. The cycle in which `trace_en` falls drains pending state exactly as `flush` does.
- R9: In a partial row, the payload bits of unused offset slots are zero.
- R10: Reset clears `row_valid`, all pending offsets, the waiting row and the region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_en | input | 1 | Tracing enable; falling edge drains pending state |
| op_valid | input | 1 | An opcode was executed this cycle |
| op_pc | input | 18 | PC of the executed opcode |
| flush | input | 1 | Drain pending state and forget the region |
| row_valid | output | 1 | Row write strobe |
| row_data | output | 20 | Row: tag in bits 19:18, payload in bits 17:0 |

## Verification
Every row comes from one register stage, so a row caused by a stimulus shows up after the next rising edge. The one exception is a full-PC row deferred by a region change, which shows up one edge later, after its partial row. The bench drives each stimulus at a falling edge and compares the outputs at the following falling edge. A deferred row therefore appears as the expected result of the next table entry, whether that entry is an idle cycle, an opcode or a flush. Cycles that must not write a row are checked for `row_valid` low in the same way.

// File: rtl/pct_pkg.sv
package pct_pkg;
    // Row tag values: full-PC row, or number of valid packed offsets.
    typedef enum logic [1:0] {
        TAG_FULL  = 2'b00,
        TAG_ONE   = 2'b01,
        TAG_TWO   = 2'b10,
        TAG_THREE = 2'b11
    } row_tag_e;
endpackage

// File: rtl/pct_region_cmp.sv
module pct_region_cmp #(
    parameter int PC_W  = 18,
    parameter int OFS_W = 6
) (
    input  logic [PC_W-1:0]       pc,
    input  logic [PC_W-OFS_W-1:0] base,
    input  logic                  base_vld,
    output logic [PC_W-OFS_W-1:0] region,
    output logic                  same
);
    assign region = pc[PC_W-1:OFS_W];
    assign same   = base_vld && (region == base);
endmodule

// File: rtl/pct_row_fmt.sv
module pct_row_fmt #(
    parameter int PC_W  = 18,
    parameter int OFS_W = 6,
    parameter int SLOTS = 3,
    parameter int CNT_W = 2
) (
    input  logic                       full_sel,
    input  logic [PC_W-1:0]            full_pc,
    input  logic [CNT_W-1:0]           cnt,
    input  logic [SLOTS-1:0][OFS_W-1:0] ofs,
    output logic [CNT_W+PC_W-1:0]      row
);
    localparam int PAY_W = SLOTS * OFS_W;

    logic [PAY_W-1:0] packed_pay;

    // Slots at or beyond the valid count are forced to zero.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign packed_pay[g*OFS_W +: OFS_W] = (CNT_W'(g) < cnt) ? ofs[g] : '0;
    end

    assign row = full_sel ? {CNT_W'(0), full_pc} : {cnt, PC_W'(packed_pay)};
endmodule

// File: rtl/pc_trace_packer.sv
module pc_trace_packer #(
    parameter int PC_W  = 18,
    parameter int OFS_W = 6,
    parameter int SLOTS = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trace_en,
    input  logic                      op_valid,
    input  logic [PC_W-1:0]           op_pc,
    input  logic                      flush,
    output logic                      row_valid,
    output logic [$clog2(SLOTS+1)+PC_W-1:0] row_data
);
    localparam int REG_W = PC_W - OFS_W;
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int ROW_W = CNT_W + PC_W;

    initial begin
        assert (SLOTS * OFS_W <= PC_W);
    end

    typedef struct packed {
        logic                       en;
        logic                       base_vld;
        logic [REG_W-1:0]           base;
        logic [CNT_W-1:0]           cnt;
        logic [SLOTS-1:0][OFS_W-1:0] ofs;
        logic                       defer_vld;
        logic [PC_W-1:0]            defer_pc;
        logic                       row_vld;
        logic [ROW_W-1:0]           row;
    } state_t;

    state_t q, d;

    logic                        flush_evt, accept, same;
    logic [REG_W-1:0]            region;
    logic                        emit, fmt_full;
    logic [PC_W-1:0]             fmt_pc;
    logic [CNT_W-1:0]            fmt_cnt;
    logic [SLOTS-1:0][OFS_W-1:0] fmt_ofs, ofs_ins;
    logic [ROW_W-1:0]            fmt_row;

    pct_region_cmp #(.PC_W(PC_W), .OFS_W(OFS_W)) u_cmp (
        .pc       (op_pc),
        .base     (q.base),
        .base_vld (q.base_vld),
        .region   (region),
        .same     (same)
    );

    pct_row_fmt #(.PC_W(PC_W), .OFS_W(OFS_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_fmt (
        .full_sel (fmt_full),
        .full_pc  (fmt_pc),
        .cnt      (fmt_cnt),
        .ofs      (fmt_ofs),
        .row      (fmt_row)
    );

    // Decide which row, if any, is written this cycle.
    always_comb begin
        flush_evt = q.en && (flush || !trace_en);
        accept    = op_valid && trace_en && !flush;
        ofs_ins   = q.ofs;
        for (int i = 0; i < SLOTS; i++) begin
            if (CNT_W'(i) == q.cnt) ofs_ins[i] = op_pc[OFS_W-1:0];
        end
        emit     = 1'b0;
        fmt_full = 1'b0;
        fmt_pc   = q.defer_pc;
        fmt_cnt  = q.cnt;
        fmt_ofs  = q.ofs;
        if (q.defer_vld) begin
            emit     = 1'b1;
            fmt_full = 1'b1;
        end else if (flush_evt) begin
            emit = (q.cnt != '0);
        end else if (accept) begin
            if (!same) begin
                emit = 1'b1;
                if (q.cnt == '0) begin
                    fmt_full = 1'b1;
                    fmt_pc   = op_pc;
                end
            end else if (q.cnt == CNT_W'(SLOTS - 1)) begin
                emit    = 1'b1;
                fmt_cnt = CNT_W'(SLOTS);
                fmt_ofs = ofs_ins;
            end
        end
    end

    // Next-state computation.
    always_comb begin
        d         = q;
        d.en      = trace_en;
        d.row_vld = emit;
        d.row     = emit ? fmt_row : '0;
        if (q.defer_vld) begin
            d.defer_vld = 1'b0;
            if (accept) begin
                if (same) begin
                    d.cnt    = CNT_W'(1);
                    d.ofs    = '0;
                    d.ofs[0] = op_pc[OFS_W-1:0];
                end else begin
                    d.defer_vld = 1'b1;
                    d.defer_pc  = op_pc;
                    d.base      = region;
                end
            end
        end else if (accept) begin
            if (!same) begin
                d.base     = region;
                d.base_vld = 1'b1;
                d.cnt      = '0;
                d.ofs      = '0;
                if (q.cnt != '0) begin
                    d.defer_vld = 1'b1;
                    d.defer_pc  = op_pc;
                end
            end else if (q.cnt == CNT_W'(SLOTS - 1)) begin
                d.cnt = '0;
                d.ofs = '0;
            end else begin
                d.ofs = ofs_ins;
                d.cnt = q.cnt + CNT_W'(1);
            end
        end
        if (flush_evt) begin
            d.base_vld  = 1'b0;
            d.cnt       = '0;
            d.ofs       = '0;
            d.defer_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign row_valid = q.row_vld;
    assign row_data  = q.row;

    // Offset count never reaches a full row while held.
    assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < CNT_W'(SLOTS));

    // An in-region opcode that does not complete a row writes nothing.
    assert_quiet_in_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && same && !q.defer_vld && q.cnt < CNT_W'(SLOTS - 1)) |=> !row_valid);

    // A waiting full-PC row implies no offsets are pending.
    assert_defer_no_offsets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.defer_vld |-> (q.cnt == '0));

    // A waiting full-PC row is always written on the next edge.
    assert_defer_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.defer_vld |=> (row_valid && row_data[ROW_W-1:PC_W] == '0));

    // Flush leaves nothing pending and forgets the region.
    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && trace_en && q.en) |=> (!q.base_vld && q.cnt == '0 && !q.defer_vld));

    // Disabled tracing writes nothing.
    assert_idle_no_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trace_en && !q.en) |=> !row_valid);
endmodule

// File: tb/pc_trace_packer_tb.sv
module pc_trace_packer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trace_en = 1'b0;
    logic        op_valid = 1'b0;
    logic [17:0] op_pc = '0;
    logic        flush = 1'b0;
    logic        row_valid;
    logic [19:0] row_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pc_trace_packer u_dut (
        .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .op_valid(op_valid),
        .op_pc(op_pc), .flush(flush), .row_valid(row_valid), .row_data(row_data)
    );

    // Vector: req[45:42] en[41] op[40] flush[39] pc[38:21] exp_valid[20] exp_row[19:0]
    localparam int NV = 26;
    localparam logic [45:0] VEC [NV] = '{
        {4'd2,  1'b1,1'b1,1'b0,18'h01005,1'b1,20'h01005}, // R2 first op full row
        {4'd3,  1'b1,1'b1,1'b0,18'h01007,1'b0,20'h00000}, // R3 offset 1
        {4'd3,  1'b1,1'b1,1'b0,18'h0100A,1'b0,20'h00000}, // R3 offset 2
        {4'd3,  1'b1,1'b1,1'b0,18'h0103F,1'b1,20'hFF287}, // R3 three offsets, tag 11
        {4'd4,  1'b1,1'b1,1'b0,18'h01040,1'b1,20'h01040}, // R4 cross, none pending
        {4'd3,  1'b1,1'b1,1'b0,18'h01041,1'b0,20'h00000}, // R3
        {4'd5,  1'b1,1'b1,1'b0,18'h02000,1'b1,20'h40001}, // R5 partial tag 01, R9 zeros
        {4'd5,  1'b1,1'b0,1'b0,18'h00000,1'b1,20'h02000}, // R5 deferred full row
        {4'd3,  1'b1,1'b1,1'b0,18'h02003,1'b0,20'h00000}, // R3
        {4'd3,  1'b1,1'b1,1'b0,18'h02005,1'b0,20'h00000}, // R3
        {4'd5,  1'b1,1'b1,1'b0,18'h03000,1'b1,20'h80143}, // R5 partial tag 10
        {4'd6,  1'b1,1'b1,1'b0,18'h04000,1'b1,20'h03000}, // R6 cross while waiting
        {4'd6,  1'b1,1'b1,1'b0,18'h04001,1'b1,20'h04000}, // R6 in-region while waiting
        {4'd7,  1'b1,1'b1,1'b1,18'h3FFFF,1'b1,20'h40001}, // R7 flush partial, op ignored
        {4'd2,  1'b1,1'b1,1'b0,18'h04002,1'b1,20'h04002}, // R2 full after flush
        {4'd3,  1'b1,1'b1,1'b0,18'h04010,1'b0,20'h00000}, // R3
        {4'd8,  1'b0,1'b1,1'b0,18'h04011,1'b1,20'h40010}, // R8 fall drains, op ignored
        {4'd8,  1'b0,1'b1,1'b0,18'h05000,1'b0,20'h00000}, // R8 disabled ignores op
        {4'd2,  1'b1,1'b1,1'b0,18'h05000,1'b1,20'h05000}, // R2 full after enable
        {4'd1,  1'b1,1'b0,1'b0,18'h00000,1'b0,20'h00000}, // R1 idle, no row
        {4'd7,  1'b1,1'b0,1'b1,18'h00000,1'b0,20'h00000}, // R7 flush with nothing pending
        {4'd2,  1'b1,1'b1,1'b0,18'h3FFC0,1'b1,20'h3FFC0}, // R2
        {4'd3,  1'b1,1'b1,1'b0,18'h3FFFF,1'b0,20'h00000}, // R3
        {4'd5,  1'b1,1'b1,1'b0,18'h00000,1'b1,20'h4003F}, // R5 partial
        {4'd7,  1'b1,1'b0,1'b1,18'h00000,1'b1,20'h00000}, // R7 flush writes waiting row
        {4'd2,  1'b1,1'b1,1'b0,18'h00001,1'b1,20'h00001}  // R2 full after flush
    };

    task automatic check(input int req, input logic ev, input logic [19:0] er);
        checks++;
        if (row_valid !== ev || (ev && row_data !== er)) begin
            errors++;
            $display("FAIL R%0d: row_valid=%0b row_data=%05h expected valid=%0b data=%05h",
                     req, row_valid, row_data, ev, er);
        end
    endtask

    task automatic drive(input logic en, input logic op, input logic fl, input logic [17:0] pc);
        trace_en = en;
        op_valid = op;
        flush    = fl;
        op_pc    = pc;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(10, 1'b0, 20'h0); // R10 reset state
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][41], VEC[i][40], VEC[i][39], VEC[i][38:21]);
            check(int'(VEC[i][45:42]), VEC[i][20], VEC[i][19:0]);
        end
        // R10: reset discards pending offsets and region
        drive(1'b1, 1'b1, 1'b0, 18'h06000);
        check(2, 1'b1, 20'h06000);
        drive(1'b1, 1'b1, 1'b0, 18'h06001);
        check(3, 1'b0, 20'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check(10, 1'b0, 20'h0);
        rst_n = 1'b1;
        drive(1'b1, 1'b1, 1'b0, 18'h06002);
        check(10, 1'b1, 20'h06002);
        drive(1'b1, 1'b0, 1'b0, 18'h0);
        check(1, 1'b0, 20'h0); // R1 row lasts one cycle
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule